// File: doc/BRIEF.md
# Oscillator Trim Auto-Calibration Controller

This block keeps an on-chip oscillator close to its intended frequency without software in the loop. A free-running counter, clocked by the oscillator being tuned, is sampled at each rising edge of a reference event whose true period is known, for example a squared-up mains signal. The difference between two consecutive samples is the measured period in device-clock cycles. That period is compared against a programmable expected count. A programmable tolerance forms a dead band around the expected count. A reading above the band means the oscillator runs fast, and a reading below it means the oscillator runs slow.

A serial receiver can add hints through two single-cycle pulses. A framing error suggests the clock is too fast. A data error suggests the clock is too slow. Every accepted hint or verdict moves a 5-bit two's-complement trim code by exactly one step. The code stops at its end values instead of wrapping around.

After each step, a programmable settle interval blocks further steps while the oscillator moves to its new frequency. Nothing reports when that new frequency has been reached.

Top module: `osc_trim_cal`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `trim_code` is 00000 (centre) and `meas_valid` is 0.
- R2: The first rising edge of `ref_evt` after reset only stores the counter value. `meas_valid` stays 0 for that edge.
- R3: Each later rising edge of `ref_evt` raises `meas_valid` for exactly the following cycle. In that cycle, `meas_period` equals the number of clock cycles between this edge and the previous one, taken modulo 2^CNT_W, so the result stays correct when the counter wraps between the two edges.
- R4: When `meas_valid` is high and `meas_period` > `expected_cnt` + `tolerance`, `trim_code` is one lower in the next cycle (oscillator fast).
- R5: When `meas_valid` is high and `meas_period` + `tolerance` < `expected_cnt`, `trim_code` is one higher in the next cycle (oscillator slow).
- R6: A measurement inside the inclusive band [`expected_cnt` − `tolerance`, `expected_cnt` + `tolerance`] leaves `trim_code` unchanged.
- R7: A `frame_err` pulse lowers `trim_code` by one and a `data_err` pulse raises it by one, with the result visible in the next cycle. When both pulse in the same cycle, the code does not change.
- R8: When an out-of-band measurement and a serial hint arrive in the same cycle, the measurement decides the direction.
- R9: `trim_code` saturates at 01111 (+15, fastest) and at 10000 (−16, slowest). A request past either end changes nothing.
- R10: After a step, every request in the next `settle_cycles` clock cycles is ignored. A request in the cycle after that is accepted. With `settle_cycles` = 0, requests in consecutive cycles are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock being calibrated |
| rst | input | 1 | Synchronous active-high reset |
| ref_evt | input | 1 | Reference event, synchronous level; each rising edge is one event |
| frame_err | input | 1 | Serial framing-error pulse (clock too fast) |
| data_err | input | 1 | Serial data-error pulse (clock too slow) |
| expected_cnt | input | CNT_W | Expected period in device-clock cycles |
| tolerance | input | CNT_W | Half-width of the dead band |
| settle_cycles | input | SETTLE_W | Lockout length after each step |
| trim_code | output | TRIM_W | Two's-complement trim code |
| meas_valid | output | 1 | One-cycle strobe for a new period |
| meas_period | output | CNT_W | Last measured period |

## Verification
The bench builds the block with CNT_W = 8, so the free counter wraps every 256 cycles. A run of reference gaps between 60 and 200 cycles therefore crosses the wrap point several times, which exercises the modulo subtraction. With an expected count of 100 and a tolerance of 3, the band edges at 97 and 103 sit within a few cycles of out-of-band gaps such as 96 and 104. A settle length of 4 makes the blocked window and the first accepted cycle after it quick to probe. The bench also sets the settle length to 0 to check back-to-back steps.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

    // Direction requested of the trim stepper in a given cycle.
    typedef enum logic [1:0] {
        NUDGE_HOLD = 2'd0,
        NUDGE_UP   = 2'd1,
        NUDGE_DOWN = 2'd2
    } nudge_e;

    // An out-of-band measurement wins over serial hints; hints that
    // contradict each other cancel out.
    function automatic nudge_e pick_nudge(input logic meas_fast,
                                          input logic meas_slow,
                                          input logic frame_hint,
                                          input logic data_hint);
        if (meas_fast)                 return NUDGE_DOWN;
        if (meas_slow)                 return NUDGE_UP;
        if (frame_hint && !data_hint)  return NUDGE_DOWN;
        if (data_hint && !frame_hint)  return NUDGE_UP;
        return NUDGE_HOLD;
    endfunction

endpackage

// File: rtl/trim_period_meter.sv
module trim_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_evt,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_period
);
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] held_cnt;
    logic             evt_q;
    logic             armed;
    logic             evt_edge;

    assign evt_edge = ref_evt & ~evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_cnt    <= '0;
            held_cnt    <= '0;
            evt_q       <= 1'b0;
            armed       <= 1'b0;
            meas_valid  <= 1'b0;
            meas_period <= '0;
        end else begin
            free_cnt   <= free_cnt + 1'b1;
            evt_q      <= ref_evt;
            meas_valid <= 1'b0;
            if (evt_edge) begin
                held_cnt <= free_cnt;
                armed    <= 1'b1;
                if (armed) begin
                    meas_valid  <= 1'b1;
                    // modulo subtraction handles counter wrap
                    meas_period <= free_cnt - held_cnt;
                end
            end
        end
    end

    // R3
    meas_follows_edge_chk: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> ($past(ref_evt) && armed));

    // R2
    first_edge_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> !meas_valid);

endmodule

// File: rtl/trim_verdict.sv
module trim_verdict
    import trim_cal_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_period,
    input  logic [CNT_W-1:0] expected_cnt,
    input  logic [CNT_W-1:0] tolerance,
    input  logic             frame_err,
    input  logic             data_err,
    output nudge_e           nudge
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] period_x;
    logic [EXT_W-1:0] upper_x;
    logic [EXT_W-1:0] period_plus_tol;
    logic             too_fast;
    logic             too_slow;

    // One extra bit keeps expected+tol and period+tol from overflowing.
    assign period_x        = {1'b0, meas_period};
    assign upper_x         = {1'b0, expected_cnt} + {1'b0, tolerance};
    assign period_plus_tol = period_x + {1'b0, tolerance};

    assign too_fast = meas_valid && (period_x > upper_x);
    assign too_slow = meas_valid && (period_plus_tol < {1'b0, expected_cnt});

    assign nudge = pick_nudge(too_fast, too_slow, frame_err, data_err);

endmodule

// File: rtl/trim_stepper.sv
module trim_stepper
    import trim_cal_pkg::*;
#(
    parameter int TRIM_W   = 5,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  nudge_e              nudge,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [TRIM_W-1:0]   trim_code
);
    localparam logic [TRIM_W-1:0] TRIM_MAX = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic [TRIM_W-1:0] TRIM_MIN = {1'b1, {(TRIM_W-1){1'b0}}};
    localparam logic [TRIM_W-1:0] ONE_UP   = TRIM_W'(1);
    localparam logic [TRIM_W-1:0] ONE_DOWN = {TRIM_W{1'b1}};

    logic [TRIM_W-1:0]   trim_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                can_up;
    logic                can_down;

    assign can_up    = (nudge == NUDGE_UP)   && (trim_q != TRIM_MAX);
    assign can_down  = (nudge == NUDGE_DOWN) && (trim_q != TRIM_MIN);
    assign trim_code = trim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q   <= '0;
            settle_q <= '0;
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end else if (can_up) begin
            trim_q   <= trim_q + 1'b1;
            settle_q <= settle_cycles;
        end else if (can_down) begin
            trim_q   <= trim_q - 1'b1;
            settle_q <= settle_cycles;
        end
    end

    // R9
    no_wrap_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(trim_q) == TRIM_MAX) |-> (trim_q != TRIM_MIN));

    // R9
    no_wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(trim_q) == TRIM_MIN) |-> (trim_q != TRIM_MAX));

    // R10
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (settle_q != '0) |=> $stable(trim_q));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (trim_q != $past(trim_q)) |->
            ((TRIM_W'(trim_q - $past(trim_q)) == ONE_UP) ||
             (TRIM_W'(trim_q - $past(trim_q)) == ONE_DOWN)));

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
    import trim_cal_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TRIM_W   = 5,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_evt,
    input  logic                frame_err,
    input  logic                data_err,
    input  logic [CNT_W-1:0]    expected_cnt,
    input  logic [CNT_W-1:0]    tolerance,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [TRIM_W-1:0]   trim_code,
    output logic                meas_valid,
    output logic [CNT_W-1:0]    meas_period
);
    nudge_e nudge;

    trim_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .ref_evt     (ref_evt),
        .meas_valid  (meas_valid),
        .meas_period (meas_period)
    );

    trim_verdict #(.CNT_W(CNT_W)) u_verdict (
        .meas_valid   (meas_valid),
        .meas_period  (meas_period),
        .expected_cnt (expected_cnt),
        .tolerance    (tolerance),
        .frame_err    (frame_err),
        .data_err     (data_err),
        .nudge        (nudge)
    );

    trim_stepper #(.TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W)) u_stepper (
        .clk           (clk),
        .rst           (rst),
        .nudge         (nudge),
        .settle_cycles (settle_cycles),
        .trim_code     (trim_code)
    );

    // R6
    inband_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && !frame_err && !data_err && meas_period == expected_cnt)
            |=> $stable(trim_code));

endmodule

// File: tb/sim_osc_trim_cal.sv
module sim_osc_trim_cal;
    localparam int CNT_W    = 8;
    localparam int TRIM_W   = 5;
    localparam int SETTLE_W = 8;
    localparam int NVEC     = 8;
    localparam int GAP_TAB   [NVEC] = '{100, 104, 96, 103, 97, 200, 60, 130};
    localparam int DELTA_TAB [NVEC] = '{0,   -1,   1,  0,   0,  -1,   1,  -1};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                ref_evt = 1'b0;
    logic                frame_err = 1'b0;
    logic                data_err = 1'b0;
    logic [CNT_W-1:0]    expected_cnt = 8'd100;
    logic [CNT_W-1:0]    tolerance = 8'd3;
    logic [SETTLE_W-1:0] settle_cycles = 8'd4;
    logic [TRIM_W-1:0]   trim_code;
    logic                meas_valid;
    logic [CNT_W-1:0]    meas_period;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    osc_trim_cal #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .SETTLE_W(SETTLE_W)) u0 (
        .clk(clk), .rst(rst), .ref_evt(ref_evt), .frame_err(frame_err),
        .data_err(data_err), .expected_cnt(expected_cnt), .tolerance(tolerance),
        .settle_cycles(settle_cycles), .trim_code(trim_code),
        .meas_valid(meas_valid), .meas_period(meas_period)
    );

    function automatic int clamp(input int v);
        if (v > 15) return 15;
        if (v < -16) return -16;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_trim(input string req);
        chk(req, int'($signed(trim_code)), model);
    endtask

    task automatic fire();
        ref_evt = 1'b1;
        @(negedge clk);
        ref_evt = 1'b0;
    endtask

    task automatic pulse(input logic fe, input logic de);
        frame_err = fe;
        data_err  = de;
        @(negedge clk);
        frame_err = 1'b0;
        data_err  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trim in reset", int'($signed(trim_code)), 0);
        chk("R1 valid in reset", int'(meas_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 trim after reset", int'($signed(trim_code)), 0);

        // arming edge
        repeat (5) @(negedge clk);
        fire();
        chk("R2 first edge no strobe", int'(meas_valid), 0);
        @(negedge clk);
        chk("R2 first edge no step", int'($signed(trim_code)), 0);

        // vector walk: gaps cross the 8-bit wrap several times
        for (int i = 0; i < NVEC; i++) begin
            repeat (GAP_TAB[i] - 2) @(negedge clk);
            fire();
            chk("R3 strobe", int'(meas_valid), 1);
            chk("R3 period", int'(meas_period), GAP_TAB[i]);
            @(negedge clk);
            chk("R3 strobe single", int'(meas_valid), 0);
            model = clamp(model + DELTA_TAB[i]);
            if (DELTA_TAB[i] < 0)      chk_trim("R4 fast decrements");
            else if (DELTA_TAB[i] > 0) chk_trim("R5 slow increments");
            else                       chk_trim("R6 band holds");
        end

        // R8: slow measurement with framing hint in same cycle
        repeat (80 - 2) @(negedge clk);
        fire();
        chk("R8 period", int'(meas_period), 80);
        pulse(1'b1, 1'b0);
        model = clamp(model + 1);
        chk_trim("R8 measurement wins");

        repeat (8) @(negedge clk);
        // R7 serial hints
        pulse(1'b1, 1'b0);
        model = clamp(model - 1);
        chk_trim("R7 frame error decrements");
        repeat (6) @(negedge clk);
        pulse(1'b0, 1'b1);
        model = clamp(model + 1);
        chk_trim("R7 data error increments");
        repeat (6) @(negedge clk);
        pulse(1'b1, 1'b1);
        chk_trim("R7 both cancel");

        // R10 settle window with settle_cycles = 4
        repeat (6) @(negedge clk);
        pulse(1'b0, 1'b1);
        model = clamp(model + 1);
        chk_trim("R10 first step");
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1);
        chk_trim("R10 blocked in window");
        pulse(1'b0, 1'b1);
        model = clamp(model + 1);
        chk_trim("R10 accepted after window");

        // R9 saturation high then low
        repeat (6) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            pulse(1'b0, 1'b1);
            model = clamp(model + 1);
            repeat (5) @(negedge clk);
        end
        chk("R9 saturate high", int'($signed(trim_code)), 15);
        for (int k = 0; k < 40; k++) begin
            pulse(1'b1, 1'b0);
            model = clamp(model - 1);
            repeat (5) @(negedge clk);
        end
        chk("R9 saturate low", int'($signed(trim_code)), -16);
        pulse(1'b0, 1'b1);
        model = clamp(model + 1);
        chk_trim("R9 leave low end");

        // R10 zero settle: back-to-back steps
        settle_cycles = '0;
        repeat (6) @(negedge clk);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        model = clamp(model + 2);
        chk_trim("R10 zero settle consecutive");

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 trim reset again", int'($signed(trim_code)), 0);
        chk("R1 valid reset again", int'(meas_valid), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule